// File: doc/BRIEF.md
# Serial Control Register Bank

This block is the configuration front end of a mixed-signal radio baseband device. A host shifts 24-bit words in over a three-wire serial link (clock, data, latch). Bits arrive most significant first and are sampled when the serial clock rises. A latch pulse after the last bit commits the word. The three lowest bits of the word choose one of eight 24-bit registers, and the whole word is stored there. The serial pins are asynchronous to the system clock. They are synchronised and edge-detected inside the block.

The block decodes the stored registers into named fields for the blocks around it. These are the synthesiser divider counts, the reference dividers and the filter calibration constant. Word 6 holds a calibration request bit that clears itself. Writing it as 1 starts a modelled calibration interval, which is a cycle counter. When the interval ends, the hardware clears the bit and stores the 4-bit result presented on `cal_result` into the same word. A latch that arrives after any bit count other than 24 throws the word away and sets a sticky framing-error flag.

Top module: `ser_ctl_bank`

## Requirements
- R1: Serial data is captured on each rising edge of `ser_clk`, most significant bit first. After exactly 24 bits, a rising edge of `ser_lat` stores the 24-bit word unchanged in the addressed register.
- R2: Word bits 2:0 select the register: code 0 selects word 1 and code 7 selects word 8 (`bank_q` slice `code*24 +: 24`). Every other register keeps its value.
- R3: Each latch pulse produces at most one register write and restarts the bit count, so a latch pulse with no new bits after a good word writes nothing.
- R4: A latch pulse after a bit count other than 24 (for example 0, 23 or 25) discards the word, and no register changes.
- R5: `frame_err` is set by the condition of R4 and stays set through later good writes until reset.
- R6: Writing word 6 (code 5) with bit 10 = 1 starts a calibration. Bit 10 (and `cal_busy`) reads 1 for at least CAL_CYCLES system clocks and then clears itself within CAL_CYCLES+3 clocks of the write.
- R7: When a calibration ends, the value on `cal_result` is stored into word 6 bits 6:3 (`cal_code`). All other bits of word 6 keep their written values.
- R8: The named field outputs are taken from the registers as follows. Words 1 and 2 give the receive and transmit M counts (bits 20:10) and A counts (bits 9:3). Words 3 and 4 give the receive and transmit reference divider values (bits 17:3). Word 8 bits 23:16 give `cal_const`.
- R9: Synchronous active-high `rst` clears all eight registers and `frame_err`, and aborts any calibration in progress.
- R10: Rewriting word 6 with bit 10 = 0 while a calibration runs cancels it: no result is deposited and bit 10 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_lat | input | 1 | Latch strobe, high only after the final bit |
| cal_result | input | 4 | Result code captured when calibration ends |
| bank_q | output | 192 | All eight registers, word n at bits (n-1)*24 +: 24 |
| rx_m | output | 11 | Receive synthesiser M count |
| rx_a | output | 7 | Receive synthesiser A count |
| tx_m | output | 11 | Transmit synthesiser M count |
| tx_a | output | 7 | Transmit synthesiser A count |
| rx_ref | output | 15 | Receive reference divider |
| tx_ref | output | 15 | Transmit reference divider |
| cal_busy | output | 1 | Calibration request bit (word 6 bit 10) |
| cal_code | output | 4 | Stored calibration result (word 6 bits 6:3) |
| cal_const | output | 8 | Calibration constant (word 8 bits 23:16) |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The embedded properties check on every cycle that the register bank holds its value when there is neither a write nor a calibration completion. They also check that the framing flag is sticky, that a latch edge never yields two consecutive writes, and that a completion pulse clears the request bit and loads the code captured from `cal_result`. The directed scenarios are needed for the rest. They show the MSB-first bit ordering, the address decode and the field mapping. They also show that short, long and empty frames are rejected without touching any register, that the calibration interval has the right length, and that a rewrite or a reset cancels a calibration in progress.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int WORD_W    = 24;
  localparam int NUM_WORDS = 8;
  localparam int ADDR_W    = $clog2(NUM_WORDS);
  localparam int CAL_IDX   = 5;   // word 6
  localparam int CAL_BIT   = 10;
  localparam int CODE_LSB  = 3;
  localparam int CODE_W    = 4;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/ctl_serial_rx.sv
module ctl_serial_rx #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_lat,
  output logic              wr_stb,
  output logic [WORD_W-1:0] wr_word,
  output logic              frame_err
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [2:0]        sclk_q, sdat_q, slat_q;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              clk_rise, lat_rise;

  assign clk_rise = sclk_q[1] & ~sclk_q[2];
  assign lat_rise = slat_q[1] & ~slat_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= '0;
      sdat_q    <= '0;
      slat_q    <= '0;
      shreg     <= '0;
      cnt       <= '0;
      wr_stb    <= 1'b0;
      wr_word   <= '0;
      frame_err <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[1:0], ser_clk};
      sdat_q <= {sdat_q[1:0], ser_dat};
      slat_q <= {slat_q[1:0], ser_lat};
      wr_stb <= 1'b0;
      if (clk_rise) begin
        shreg <= {shreg[WORD_W-2:0], sdat_q[1]};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
      if (lat_rise) begin
        cnt <= '0;
        if (cnt == CNT_FULL) begin
          wr_stb  <= 1'b1;
          wr_word <= shreg;
        end else begin
          frame_err <= 1'b1;
        end
      end
    end
  end

  // R3: a single latch edge yields a one-cycle write strobe
  p_single_write_r3: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
  // R5: framing error is sticky until reset
  p_ferr_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> frame_err);
endmodule

// File: rtl/ctl_cal_timer.sv
module ctl_cal_timer #(
  parameter int CAL_CYCLES = 150000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cancel,
  output logic busy,
  output logic done
);
  localparam int TW = $clog2(CAL_CYCLES + 1);
  localparam logic [TW-1:0] LAST = TW'(CAL_CYCLES - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt  <= '0;
        busy <= 1'b1;
      end else if (cancel) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R6: completion is a single pulse that ends a running interval
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [W-1:0]      wr_word,
  input  logic              cal_done,
  input  logic [CODE_W-1:0] cal_result,
  output logic              cal_start,
  output logic              cal_cancel,
  output logic [N*W-1:0]    bank_flat
);
  localparam int AW = $clog2(N);

  logic [AW-1:0] waddr;
  assign waddr = wr_word[AW-1:0];

  assign cal_start  = wr_stb && (waddr == AW'(CAL_IDX)) &&  wr_word[CAL_BIT];
  assign cal_cancel = wr_stb && (waddr == AW'(CAL_IDX)) && !wr_word[CAL_BIT];

  for (genvar g = 0; g < N; g++) begin : g_word
    logic [W-1:0] r;
    assign bank_flat[g*W +: W] = r;
    if (g == CAL_IDX) begin : g_cal
      always_ff @(posedge clk) begin
        if (rst) begin
          r <= '0;
        end else if (wr_stb && waddr == AW'(g)) begin
          r <= wr_word;
        end else if (cal_done) begin
          r[CAL_BIT]                <= 1'b0;
          r[CODE_LSB +: CODE_W]     <= cal_result;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)                               r <= '0;
        else if (wr_stb && waddr == AW'(g))    r <= wr_word;
      end
    end
  end

  // R2: without a write or completion the whole bank is stable
  p_bank_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!wr_stb && !cal_done) |=> $stable(bank_flat));
  // R6: completion clears the request bit
  p_cal_selfclear_r6: assert property (@(posedge clk) disable iff (rst)
    (cal_done && !wr_stb) |=> !bank_flat[CAL_IDX*W + CAL_BIT]);
  // R7: completion stores the presented result code
  p_cal_code_load_r7: assert property (@(posedge clk) disable iff (rst)
    (cal_done && !wr_stb) |=>
      bank_flat[CAL_IDX*W + CODE_LSB +: CODE_W] == $past(cal_result));
endmodule

// File: rtl/ser_ctl_bank.sv
module ser_ctl_bank
  import ctl_pkg::*;
#(
  parameter int CAL_CYCLES = 150000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ser_clk,
  input  logic                      ser_dat,
  input  logic                      ser_lat,
  input  logic [CODE_W-1:0]         cal_result,
  output logic [NUM_WORDS*WORD_W-1:0] bank_q,
  output logic [10:0]               rx_m,
  output logic [6:0]                rx_a,
  output logic [10:0]               tx_m,
  output logic [6:0]                tx_a,
  output logic [14:0]               rx_ref,
  output logic [14:0]               tx_ref,
  output logic                      cal_busy,
  output logic [CODE_W-1:0]         cal_code,
  output logic [7:0]                cal_const,
  output logic                      frame_err
);
  logic        wr_stb;
  word_t       wr_word;
  logic        cal_start, cal_cancel, cal_run, cal_done;

  ctl_serial_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_lat(ser_lat), .wr_stb(wr_stb), .wr_word(wr_word),
    .frame_err(frame_err)
  );

  ctl_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(cal_start), .cancel(cal_cancel),
    .busy(cal_run), .done(cal_done)
  );

  ctl_reg_bank #(.W(WORD_W), .N(NUM_WORDS)) u_bank (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_word(wr_word),
    .cal_done(cal_done), .cal_result(cal_result),
    .cal_start(cal_start), .cal_cancel(cal_cancel), .bank_flat(bank_q)
  );

  function automatic word_t word_of(input int idx);
    return bank_q[idx*WORD_W +: WORD_W];
  endfunction

  always_comb begin
    word_t w0, w1, w2, w3, w5, w7;
    w0 = word_of(0);
    w1 = word_of(1);
    w2 = word_of(2);
    w3 = word_of(3);
    w5 = word_of(CAL_IDX);
    w7 = word_of(7);
    rx_m      = w0[20:10];
    rx_a      = w0[9:3];
    tx_m      = w1[20:10];
    tx_a      = w1[9:3];
    rx_ref    = w2[17:3];
    tx_ref    = w3[17:3];
    cal_busy  = w5[CAL_BIT];
    cal_code  = w5[CODE_LSB +: CODE_W];
    cal_const = w7[23:16];
  end

  // R6: the request bit can only rise through a write strobe
  p_busy_rise_by_write_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_busy) |-> $past(wr_stb));
endmodule

// File: tb/test_ser_ctl_bank.sv
module test_ser_ctl_bank;
  localparam int CAL = 400;

  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
  logic [3:0] cal_result = 4'hA;
  logic [191:0] bank_q;
  logic [10:0] rx_m, tx_m;
  logic [6:0]  rx_a, tx_a;
  logic [14:0] rx_ref, tx_ref;
  logic cal_busy, frame_err;
  logic [3:0] cal_code;
  logic [7:0] cal_const;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ser_ctl_bank #(.CAL_CYCLES(CAL)) i_ser_ctl_bank (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_lat(ser_lat), .cal_result(cal_result), .bank_q(bank_q),
    .rx_m(rx_m), .rx_a(rx_a), .tx_m(tx_m), .tx_a(tx_a),
    .rx_ref(rx_ref), .tx_ref(tx_ref), .cal_busy(cal_busy),
    .cal_code(cal_code), .cal_const(cal_const), .frame_err(frame_err)
  );

  task automatic chk(input string req, input logic [191:0] act, input logic [191:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] wd(input int idx);
    return bank_q[idx*24 +: 24];
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = w[i];
      cyc(3); ser_clk = 1'b1;
      cyc(6); ser_clk = 1'b0;
      cyc(3);
    end
  endtask

  task automatic latch();
    cyc(4); ser_lat = 1'b1;
    cyc(6); ser_lat = 1'b0;
    cyc(10);
  endtask

  task automatic send_word(input logic [23:0] w);
    send_bits({8'h0, w}, 24);
    latch();
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(4); rst = 1'b0; cyc(2);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9 bank clear", bank_q, '0);
    chk("R9 ferr clear", frame_err, 0);
    chk("R9 busy clear", cal_busy, 0);
  endtask

  task automatic t_synth();
    send_word(24'((11'h5A3 << 10) | (7'h2B << 3) | 0));
    chk("R8 rx_m", rx_m, 11'h5A3);
    chk("R8 rx_a", rx_a, 7'h2B);
    chk("R1 word1 exact", wd(0), 24'((11'h5A3 << 10) | (7'h2B << 3)));
    send_word(24'((11'h1C6 << 10) | (7'h51 << 3) | 1));
    chk("R8 tx_m", tx_m, 11'h1C6);
    chk("R8 tx_a", tx_a, 7'h51);
    send_word(24'((15'h6ABC << 3) | 2));
    chk("R8 rx_ref", rx_ref, 15'h6ABC);
    send_word(24'((15'h1357 << 3) | 3));
    chk("R8 tx_ref", tx_ref, 15'h1357);
  endtask

  task automatic t_addr();
    logic [23:0] w1 = wd(0);
    send_word(24'h0C0007);
    chk("R8 cal_const", cal_const, 8'h0C);
    chk("R2 word8", wd(7), 24'h0C0007);
    send_word(24'hFFFFFC);
    chk("R2 word5", wd(4), 24'hFFFFFC);
    chk("R2 word1 untouched", wd(0), w1);
    chk("R2 word8 untouched", wd(7), 24'h0C0007);
  endtask

  task automatic t_frames();
    logic [191:0] snap;
    send_word(24'hA5A5A6);
    chk("R1 word7", wd(6), 24'hA5A5A6);
    snap = bank_q;
    latch();
    chk("R3 bare latch no write", bank_q, snap);
    chk("R3 bare latch flags", frame_err, 1);
    do_reset();
    send_word(24'h123456);
    snap = bank_q;
    send_bits(32'h7ABCDE, 23); latch();
    chk("R4 short frame", bank_q, snap);
    chk("R5 ferr set", frame_err, 1);
    send_bits(32'h1F0F0F1, 25); latch();
    chk("R4 long frame", bank_q, snap);
    send_word(24'h0F0F0E);
    chk("R1 good after bad", wd(6), 24'h0F0F0E);
    chk("R5 ferr sticky", frame_err, 1);
  endtask

  task automatic t_cal();
    do_reset();
    cal_result = 4'hA;
    send_word(24'h002405);
    cyc(150);
    chk("R6 busy mid", cal_busy, 1);
    chk("R6 code not yet", cal_code, 0);
    cyc(300);
    chk("R6 selfclear", cal_busy, 0);
    chk("R7 code", cal_code, 4'hA);
    chk("R7 word6 rest", wd(5), 24'h002055);
  endtask

  task automatic t_cancel();
    do_reset();
    cal_result = 4'h6;
    send_word(24'h002405);
    send_word(24'h000005);
    cyc(CAL + 100);
    chk("R10 cancel bit", cal_busy, 0);
    chk("R10 no code", wd(5), 24'h000005);
  endtask

  task automatic t_reset_mid();
    cal_result = 4'h3;
    send_word(24'h000405);
    cyc(20);
    do_reset();
    chk("R9 abort busy", cal_busy, 0);
    cyc(CAL + 50);
    chk("R9 abort no code", bank_q, '0);
  endtask

  initial begin
    t_reset();
    t_synth();
    t_addr();
    t_frames();
    t_cal();
    t_cancel();
    t_reset_mid();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule